// File: doc/BRIEF.md
# Paged MDIO Register Bridge

This block sits behind an MDIO slave front end that has already decoded each management frame into one transaction: PHY address, register number, read or write, and 16 bits of data. Transactions aimed at one reserved PHY address are turned into accesses of a 32-bit internal register bus. All other transactions are handed on unchanged to the real PHYs sharing the management bus.

A 32-bit register is reached in steps. A page register holds the upper internal address bits. The sixteen word registers pick a word inside the page. A separate register carries the upper 16 data bits. Writing a word register only stages the lower half. The internal write happens when the upper half is written. Reading a word register performs the full 32-bit internal read. It returns the lower half and keeps the upper half for a later read of the upper-half register.

Top module: `paged_mdio_bridge`

## Requirements
- R1: Transactions whose PHY address is not 31 appear on the `pt_*` outputs in the same cycle with every field unchanged. They cause no internal access and change no bridge state. A pass-through response on `pt_rsp_*` is forwarded to `rsp_*`.
- R2: A write to register 31 at PHY 31 loads the 10-bit page from write data bits [9:0]; upper data bits are dropped. A read of register 31 returns the page, zero-extended to 16 bits.
- R3: Every internal access uses the 16-bit address {page, word index, 2'b00}. The word index is register number bits [3:0].
- R4: A write to a word register (0 to 15) stores the 16-bit value in a staging register and records the word index. It starts no internal access.
- R5: A write to register 16 drives `reg_we` high for exactly the next cycle. The data is {written value, staged lower half}. The address uses the word index of the most recent word-register access, read or write.
- R6: A read of a word register drives `reg_re` high for exactly the next cycle and records the word index. The lower 16 bits of `reg_rdata` in that cycle are the response.
- R7: A read of register 16 returns the upper half captured by the most recent word-register read. This holds even when the two reads are in consecutive cycles.
- R8: Registers 17 to 30 at PHY 31 read as zero. Writing them has no effect.
- R9: Reset clears the page, the staging register, the word index and the captured upper half to zero.
- R10: Every read at PHY 31 gives a one-cycle `rsp_valid` pulse exactly two cycles after the transaction cycle. A write never gives one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| txn_valid | input | 1 | Decoded management transaction present this cycle |
| txn_phy | input | 5 | PHY address of the transaction |
| txn_reg | input | 5 | Register number |
| txn_write | input | 1 | 1 = write, 0 = read |
| txn_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_rdata | output | 16 | Read response data |
| pt_valid | output | 1 | Forwarded transaction for other PHYs |
| pt_phy | output | 5 | Forwarded PHY address |
| pt_reg | output | 5 | Forwarded register number |
| pt_write | output | 1 | Forwarded direction |
| pt_wdata | output | 16 | Forwarded write data |
| pt_rsp_valid | input | 1 | Response from the other PHYs |
| pt_rsp_rdata | input | 16 | Response data from the other PHYs |
| reg_addr | output | 16 | Internal byte address |
| reg_wdata | output | 32 | Internal write data |
| reg_we | output | 1 | Internal write strobe |
| reg_re | output | 1 | Internal read strobe; `reg_rdata` is sampled in the same cycle |
| reg_rdata | input | 32 | Internal read data |

## Verification
The pass-through outputs are combinational and are checked one time step after inputs are driven. The internal strobes, address and write data appear in the cycle after the transaction cycle. Read responses appear two cycles after it. The bench model places each expected value in the cycle where it is due. It compares at the falling edge, so every result is checked exactly in its cycle and never one cycle early or late. Back-to-back pairs check that a page write is seen by the next access, and that a word read is seen by an upper-half read in the next cycle.

// File: rtl/paged_mdio_bridge.sv
module paged_mdio_bridge #(
  parameter int PHY_W      = 5,
  parameter int REG_W      = 5,
  parameter int DATA_W     = 16,
  parameter int PAGE_W     = 10,
  parameter int IDX_W      = 4,
  parameter int BRIDGE_PHY = 31,
  parameter int PAGE_REG   = 31,
  parameter int HI_REG     = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        txn_valid,
  input  logic [PHY_W-1:0]            txn_phy,
  input  logic [REG_W-1:0]            txn_reg,
  input  logic                        txn_write,
  input  logic [DATA_W-1:0]           txn_wdata,
  output logic                        rsp_valid,
  output logic [DATA_W-1:0]           rsp_rdata,
  output logic                        pt_valid,
  output logic [PHY_W-1:0]            pt_phy,
  output logic [REG_W-1:0]            pt_reg,
  output logic                        pt_write,
  output logic [DATA_W-1:0]           pt_wdata,
  input  logic                        pt_rsp_valid,
  input  logic [DATA_W-1:0]           pt_rsp_rdata,
  output logic [PAGE_W+IDX_W+1:0]     reg_addr,
  output logic [2*DATA_W-1:0]         reg_wdata,
  output logic                        reg_we,
  output logic                        reg_re,
  input  logic [2*DATA_W-1:0]         reg_rdata
);

  localparam logic [PHY_W-1:0] MY_PHY   = PHY_W'(BRIDGE_PHY);
  localparam logic [REG_W-1:0] PG_REG   = REG_W'(PAGE_REG);
  localparam logic [REG_W-1:0] UP_REG   = REG_W'(HI_REG);
  localparam logic [REG_W:0]   N_WORDS  = (REG_W+1)'(1 << IDX_W);

  logic hit, is_word, is_hi, is_page;
  logic [PAGE_W-1:0] page_q;
  logic [DATA_W-1:0] stage_q, hi_q;
  logic [IDX_W-1:0]  idx_q;
  logic              s1_v, s1_word, s1_hi;
  logic [DATA_W-1:0] s1_misc;
  logic              own_v;
  logic [DATA_W-1:0] own_d;

  assign hit     = txn_valid && (txn_phy == MY_PHY);
  assign is_word = {1'b0, txn_reg} < N_WORDS;
  assign is_hi   = txn_reg == UP_REG;
  assign is_page = txn_reg == PG_REG;

  assign pt_valid = txn_valid && !hit;
  assign pt_phy   = txn_phy;
  assign pt_reg   = txn_reg;
  assign pt_write = txn_write;
  assign pt_wdata = txn_wdata;

  assign rsp_valid = own_v | pt_rsp_valid;
  assign rsp_rdata = own_v ? own_d : pt_rsp_rdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      page_q    <= '0;
      stage_q   <= '0;
      idx_q     <= '0;
      hi_q      <= '0;
      reg_we    <= 1'b0;
      reg_re    <= 1'b0;
      reg_addr  <= '0;
      reg_wdata <= '0;
      s1_v      <= 1'b0;
      s1_word   <= 1'b0;
      s1_hi     <= 1'b0;
      s1_misc   <= '0;
      own_v     <= 1'b0;
      own_d     <= '0;
    end else begin
      reg_we <= hit && txn_write && is_hi;
      reg_re <= hit && !txn_write && is_word;
      if (hit && txn_write && is_page) page_q <= txn_wdata[PAGE_W-1:0];
      if (hit && is_word) begin
        idx_q <= txn_reg[IDX_W-1:0];
        if (txn_write) stage_q <= txn_wdata;
      end
      if (hit && txn_write && is_hi) begin
        reg_addr  <= {page_q, idx_q, 2'b00};
        reg_wdata <= {txn_wdata, stage_q};
      end
      if (hit && !txn_write && is_word) reg_addr <= {page_q, txn_reg[IDX_W-1:0], 2'b00};

      s1_v    <= hit && !txn_write;
      s1_word <= is_word;
      s1_hi   <= is_hi;
      s1_misc <= is_page ? DATA_W'(page_q) : '0;

      own_v <= s1_v;
      if (s1_v) begin
        if (s1_word) begin
          own_d <= reg_rdata[DATA_W-1:0];
          hi_q  <= reg_rdata[2*DATA_W-1:DATA_W];
        end else if (s1_hi) begin
          own_d <= hi_q;
        end else begin
          own_d <= s1_misc;
        end
      end
    end
  end

  p_single_access_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_re));

  p_hi_write_commits_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hit && txn_write && is_hi |=> reg_we);

  p_low_write_staged_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hit && txn_write && is_word |=> !reg_we && !reg_re);

  p_word_read_fetch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hit && !txn_write && is_word |=> reg_re);

  p_pass_no_access_r1: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid && !hit |=> !reg_we && !reg_re);

  p_rsp_due_r10: assert property (@(posedge clk) disable iff (!rst_n)
    hit && !txn_write |=> ##1 rsp_valid);

  p_page_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit && txn_write && is_page) |=> $stable(page_q));

endmodule

// File: tb/paged_mdio_bridge_tb.sv
module paged_mdio_bridge_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        txn_valid = 1'b0;
  logic [4:0]  txn_phy = '0;
  logic [4:0]  txn_reg = '0;
  logic        txn_write = 1'b0;
  logic [15:0] txn_wdata = '0;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic        pt_valid;
  logic [4:0]  pt_phy;
  logic [4:0]  pt_reg;
  logic        pt_write;
  logic [15:0] pt_wdata;
  logic        pt_rsp_valid = 1'b0;
  logic [15:0] pt_rsp_rdata = '0;
  logic [15:0] reg_addr;
  logic [31:0] reg_wdata;
  logic        reg_we;
  logic        reg_re;
  logic [31:0] reg_rdata;

  always #4 clk = ~clk;

  paged_mdio_bridge u_dut (
    .clk(clk), .rst_n(rst_n),
    .txn_valid(txn_valid), .txn_phy(txn_phy), .txn_reg(txn_reg),
    .txn_write(txn_write), .txn_wdata(txn_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .pt_valid(pt_valid), .pt_phy(pt_phy), .pt_reg(pt_reg),
    .pt_write(pt_write), .pt_wdata(pt_wdata),
    .pt_rsp_valid(pt_rsp_valid), .pt_rsp_rdata(pt_rsp_rdata),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
    .reg_re(reg_re), .reg_rdata(reg_rdata)
  );

  int n_vec = 0;
  int n_bad = 0;

  logic [31:0] env_mem [256];
  assign reg_rdata = env_mem[reg_addr[9:2]];

  logic        q1_v;
  logic [15:0] q1_d;

  // reference model state
  int          m_page, m_stage, m_idx, m_hi;
  bit          pend_v;
  int          pend_kind;
  logic [15:0] pend_val, pend_addr;
  string       pend_tag;
  bit          e_we, e_re, e_rv;
  logic [15:0] e_addr, e_rd;
  logic [31:0] e_wdata;
  string       e_tag, we_tag;

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: %s got %h expected %h at %0t", tag, what, act, exp, $time);
    end
  endtask

  initial for (int i = 0; i < 256; i++) env_mem[i] = 32'hA5000000 ^ (i * 32'h01030107);

  always @(posedge clk) begin
    logic [31:0] d;
    if (!rst_n) begin
      m_page = 0; m_stage = 0; m_idx = 0; m_hi = 0;
      pend_v = 0; e_we = 0; e_re = 0; e_rv = 0;
      e_addr = '0; e_wdata = '0; e_rd = '0; e_tag = "R10"; we_tag = "R9";
      q1_v <= 1'b0; q1_d <= '0; pt_rsp_valid <= 1'b0; pt_rsp_rdata <= '0;
    end else begin
      e_rv = 0;
      if (pend_v) begin
        e_rv = 1; e_tag = pend_tag;
        case (pend_kind)
          0: begin d = env_mem[pend_addr[9:2]]; e_rd = d[15:0]; m_hi = int'(d[31:16]); end
          1: e_rd = m_hi[15:0];
          default: e_rd = pend_val;
        endcase
        pend_v = 0;
      end
      e_we = 0; e_re = 0; we_tag = "R5";
      if (txn_valid) begin
        if (txn_phy != 5'd31) begin
          we_tag = "R1";
          if (!txn_write) begin
            pend_v = 1; pend_kind = 2; pend_val = {txn_phy, txn_reg, 6'h15}; pend_tag = "R1";
          end
        end else if (txn_reg < 5'd16) begin
          m_idx = int'(txn_reg);
          if (txn_write) begin
            m_stage = int'(txn_wdata); we_tag = "R4";
          end else begin
            e_re = 1; e_addr = {m_page[9:0], txn_reg[3:0], 2'b00};
            pend_v = 1; pend_kind = 0; pend_addr = e_addr; pend_tag = "R6";
          end
        end else if (txn_reg == 5'd16) begin
          if (txn_write) begin
            e_we = 1; e_addr = {m_page[9:0], m_idx[3:0], 2'b00};
            e_wdata = {txn_wdata, m_stage[15:0]};
          end else begin
            pend_v = 1; pend_kind = 1; pend_tag = "R7";
          end
        end else if (txn_reg == 5'd31) begin
          if (txn_write) m_page = int'(txn_wdata[9:0]);
          else begin
            pend_v = 1; pend_kind = 2; pend_val = 16'(m_page); pend_tag = "R2";
          end
        end else begin
          we_tag = "R8";
          if (!txn_write) begin
            pend_v = 1; pend_kind = 2; pend_val = '0; pend_tag = "R8";
          end
        end
      end
      if (reg_we) env_mem[reg_addr[9:2]] <= reg_wdata;
      q1_v <= pt_valid && !pt_write;
      q1_d <= {pt_phy, pt_reg, 6'h15};
      pt_rsp_valid <= q1_v;
      pt_rsp_rdata <= q1_d;
    end
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      chk("R9", "reg_we in reset", 32'(reg_we), 0);
      chk("R9", "rsp_valid in reset", 32'(rsp_valid), 0);
    end else begin
      chk(we_tag, "reg_we", 32'(reg_we), 32'(e_we));
      chk("R6", "reg_re", 32'(reg_re), 32'(e_re));
      if (e_we) begin
        chk("R5", "reg_wdata", reg_wdata, e_wdata);
        chk("R3", "reg_addr on write", 32'(reg_addr), 32'(e_addr));
      end
      if (e_re) chk("R3", "reg_addr on read", 32'(reg_addr), 32'(e_addr));
      chk("R10", "rsp_valid", 32'(rsp_valid), 32'(e_rv));
      if (e_rv) chk(e_tag, "rsp_rdata", 32'(rsp_rdata), 32'(e_rd));
    end
  end

  task automatic txn(input logic [4:0] phy, input logic [4:0] rg, input logic wr, input logic [15:0] d);
    @(negedge clk);
    txn_valid = 1'b1; txn_phy = phy; txn_reg = rg; txn_write = wr; txn_wdata = d;
    #1;
    chk("R1", "pt_valid", 32'(pt_valid), 32'(phy != 5'd31));
    if (phy != 5'd31) begin
      chk("R1", "pt fields", {pt_phy, pt_reg, pt_write, pt_wdata}, {phy, rg, wr, d});
    end
  endtask

  task automatic idle();
    @(negedge clk);
    txn_valid = 1'b0;
  endtask

  task automatic read_expect(input logic [4:0] rg, input logic [15:0] exp, input string tag);
    txn(5'd31, rg, 1'b0, '0);
    idle();
    @(negedge clk);
    #2;
    chk(tag, "directed read", 32'(rsp_rdata), 32'(exp));
  endtask

  initial begin
    logic [15:0] lfsr;
    lfsr = 16'hACE1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    read_expect(5'd31, 16'h0000, "R9");
    read_expect(5'd16, 16'h0000, "R9");
    // R2: page load ignores upper data bits
    txn(5'd31, 5'd31, 1'b1, 16'hFD55); idle();
    read_expect(5'd31, 16'h0155, "R2");
    // R4 then R5: staged low half, commit on upper half
    txn(5'd31, 5'd5, 1'b1, 16'h1234);
    txn(5'd31, 5'd16, 1'b1, 16'hABCD); idle(); idle();
    // R6 then R7 back to back
    txn(5'd31, 5'd5, 1'b0, '0);
    txn(5'd31, 5'd16, 1'b0, '0); idle(); idle(); idle();
    // R8: unmapped write has no effect, reads zero
    txn(5'd31, 5'd21, 1'b1, 16'hFFFF); idle();
    read_expect(5'd21, 16'h0000, "R8");
    read_expect(5'd16, 16'hABCD, "R8");
    // R1: pass-through traffic, including register numbers the bridge decodes
    txn(5'd3, 5'd16, 1'b1, 16'h5A5A);
    txn(5'd3, 5'd2, 1'b0, '0);
    txn(5'd30, 5'd31, 1'b1, 16'h0001); idle();
    read_expect(5'd31, 16'h0155, "R1");
    // R5: word index taken from the latest word read
    txn(5'd31, 5'd9, 1'b0, '0);
    txn(5'd31, 5'd16, 1'b1, 16'h7777); idle(); idle();
    // R2/R3: page change immediately followed by access
    txn(5'd31, 5'd31, 1'b1, 16'h0002);
    txn(5'd31, 5'd0, 1'b0, '0);
    txn(5'd31, 5'd31, 1'b1, 16'h03FF);
    txn(5'd31, 5'd15, 1'b1, 16'hBEEF);
    txn(5'd31, 5'd16, 1'b1, 16'hF00D); idle(); idle();
    for (int k = 0; k < 600; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (lfsr[2:0] == 3'd0) idle();
      else txn(lfsr[3] && lfsr[4] ? 5'(lfsr[9:7]) : 5'd31,
               lfsr[6:5] == 2'd0 ? 5'd16 : lfsr[6:5] == 2'd1 ? 5'(lfsr[13:10] | 5'd16) : 5'(lfsr[13:10]),
               lfsr[14], {lfsr[7:0], lfsr[15:8]});
    end
    idle(); idle(); idle();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL R10: watchdog expired got %h expected %h", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule